// File: doc/BRIEF.md
# Multi-Unit Adder Issue Interlock

This block is the decode-side issue and interlock control for an in-order pipeline. The pipeline has several parallel adder units. None of the units is pipelined internally, and each has its own write-back stage. Decoded instructions arrive over a valid/ready handshake, each carrying a destination register, two source registers and a tag. The block holds an instruction in decode, by lowering `in_ready`, until two conditions are met. First, every register it names must be free of an outstanding write. Second, an adder unit must be available to take it. Once both hold, the block sends the instruction to the lowest-numbered available unit.

Each unit spends three cycles executing and two cycles writing back. The register-file write and the retire pulse occur in the final write-back cycle. The register file passes a value to decode in the same cycle it is written, and that is the only bypass. A reader waiting on a register is therefore released in the very cycle its producer finishes. A scoreboard keeps one pending bit per register. The bit is set when an instruction issues and cleared when that instruction finishes. Because completion can be out of order, an instruction whose destination is still pending is held as well. The adder datapath itself lies outside this block, so the write port carries the register index and the instruction tag.

Top module: `add_issue_interlock`

## Requirements
- R1: After reset every unit is idle and no register is pending. `in_ready` is 1, `rf_we` is all zeros and `retire_cnt` is 0.
- R2: An instruction is held (`in_ready` = 0) while either of its sources is pending. It is accepted in the cycle in which the producer of that source performs its write. This is the same-cycle register-file forwarding. Behind a producer accepted in cycle t, a dependent instruction offered from cycle t+1 stalls for exactly 4 cycles.
- R3: An instruction is also held while its destination register is pending. The release rule and the 4-cycle stall are the same as in R2.
- R4: An instruction accepted in cycle t is written in cycle t+5, for exactly one cycle. The write is on the `rf_we` bit of the unit it was sent to. `rf_waddr` slice u (bits u*4+3..u*4) carries its destination, and `rf_wtag` slice u (bits u*8+7..u*8) carries its tag.
- R5: When no unit is available, `in_ready` is 0. A unit becomes available again in its final write-back cycle, so each instruction occupies its unit for 5 cycles.
- R6: An accepted instruction is sent to the lowest-indexed available unit, and `rf_we` bit u identifies unit u.
- R7: `retire_cnt` equals the number of `rf_we` bits set in the same cycle.
- R8: Independent instructions are accepted on consecutive cycles while units remain.
- R9: If a register's old writer finishes in the same cycle that a new writer of that register is accepted, the register stays pending. A later reader of it waits for the new writer.
- R10: A cycle with `in_valid` = 0 issues nothing, even when `in_ready` is 1. No write results from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction can issue this cycle |
| in_dst | input | 4 | Destination register |
| in_src_a | input | 4 | First source register |
| in_src_b | input | 4 | Second source register |
| in_tag | input | 8 | Instruction tag carried to write-back |
| rf_we | output | 3 | Per-unit register-file write strobe |
| rf_waddr | output | 12 | Per-unit write register, 4 bits per unit |
| rf_wtag | output | 24 | Per-unit tag of the writing instruction, 8 bits per unit |
| retire_cnt | output | 2 | Instructions retiring this cycle |

## Verification
The directed patterns each isolate one cause of a stall. A read-after-write pair and a write-after-write pair each show whether release happens in the producer's final write-back cycle or one cycle off. Four back-to-back independent instructions show that the structural stall lasts exactly two cycles and that the freed unit 0 is reused. A triple of the form writer, rewriter, reader shows whether a set and a clear of the same register in one cycle keep the bit set. After these, a long random stream runs over a small register window with gaps in `in_valid`. It mixes all the hazards and is compared cycle by cycle with a bench-side timing model. This separates errors in unit priority, tag routing and counter length.

// File: rtl/aii_pkg.sv
package aii_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_EXEC = 2'd1,
    STG_WB   = 2'd2
  } unit_stage_e;

  // A register blocks decode when a write is outstanding and that write
  // does not land in the current cycle (same-cycle register-file forwarding).
  function automatic logic reg_blocked(input logic pend, input logic landing);
    return pend & ~landing;
  endfunction

endpackage

// File: rtl/aii_unit.sv
module aii_unit
  import aii_pkg::*;
#(
  parameter int EX_CYC = 3,
  parameter int WB_CYC = 2,
  parameter int RW     = 4,
  parameter int TAG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RW-1:0]    start_dst,
  input  logic [TAG_W-1:0] start_tag,
  output logic             busy,
  output logic             free,
  output logic             wb_last,
  output logic [RW-1:0]    dst,
  output logic [TAG_W-1:0] tag
);

  localparam int MAXC = (EX_CYC > WB_CYC) ? EX_CYC : WB_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  unit_stage_e    stage;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= STG_IDLE;
      cnt   <= '0;
      dst   <= '0;
      tag   <= '0;
    end else if (start) begin
      stage <= STG_EXEC;
      cnt   <= CW'(EX_CYC - 1);
      dst   <= start_dst;
      tag   <= start_tag;
    end else begin
      case (stage)
        STG_EXEC: begin
          if (cnt == '0) begin
            stage <= STG_WB;
            cnt   <= CW'(WB_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        STG_WB: begin
          if (cnt == '0) stage <= STG_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: stage <= STG_IDLE;
      endcase
    end
  end

  assign wb_last = (stage == STG_WB) && (cnt == '0);
  assign busy    = (stage != STG_IDLE);
  assign free    = (stage == STG_IDLE) || wb_last;

endmodule

// File: rtl/aii_pick.sv
module aii_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] avail,
  output logic [N-1:0] grant,
  output logic         any
);

  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (avail[i]) grant = N'(1) << i;
    end
  end

  assign any = |avail;

endmodule

// File: rtl/aii_scoreboard.sv
module aii_scoreboard
  import aii_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int RW       = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [RW-1:0]       set_reg,
  input  logic [NUM_REGS-1:0] landing,
  input  logic [RW-1:0]       q_src_a,
  input  logic [RW-1:0]       q_src_b,
  input  logic [RW-1:0]       q_dst,
  output logic [NUM_REGS-1:0] pending,
  output logic                hazard
);

  logic [NUM_REGS-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_reg] = 1'b1;
  end

  // Clear of a finishing write and set of a new writer may hit the same
  // register in one cycle: the set wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~landing) | set_vec;
  end

  assign hazard = reg_blocked(pending[q_src_a], landing[q_src_a]) |
                  reg_blocked(pending[q_src_b], landing[q_src_b]) |
                  reg_blocked(pending[q_dst],   landing[q_dst]);

endmodule

// File: rtl/add_issue_interlock.sv
module add_issue_interlock #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_UNITS = 3,
  parameter int EX_CYC    = 3,
  parameter int WB_CYC    = 2,
  parameter int TAG_W     = 8,
  localparam int RW       = $clog2(NUM_REGS),
  localparam int CNT_W    = $clog2(NUM_UNITS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [RW-1:0]              in_dst,
  input  logic [RW-1:0]              in_src_a,
  input  logic [RW-1:0]              in_src_b,
  input  logic [TAG_W-1:0]           in_tag,
  output logic [NUM_UNITS-1:0]       rf_we,
  output logic [NUM_UNITS*RW-1:0]    rf_waddr,
  output logic [NUM_UNITS*TAG_W-1:0] rf_wtag,
  output logic [CNT_W-1:0]           retire_cnt
);

  function automatic logic [CNT_W-1:0] pop_units(input logic [NUM_UNITS-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_UNITS; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  // Named internal events, also observed by the checker.
  logic [NUM_UNITS-1:0] unit_free;
  logic [NUM_UNITS-1:0] unit_busy;
  logic [NUM_UNITS-1:0] unit_last;
  logic [NUM_UNITS-1:0] unit_grant;
  logic [NUM_UNITS-1:0] unit_start;
  logic [NUM_REGS-1:0]  reg_landing;
  logic [NUM_REGS-1:0]  reg_pending;
  logic                 any_free;
  logic                 dep_hazard;
  logic                 issue_fire;

  logic [RW-1:0]    u_dst [NUM_UNITS];
  logic [TAG_W-1:0] u_tag [NUM_UNITS];

  aii_pick #(.N(NUM_UNITS)) u_pick (
    .avail (unit_free),
    .grant (unit_grant),
    .any   (any_free)
  );

  assign in_ready   = any_free & ~dep_hazard;
  assign issue_fire = in_valid & in_ready;
  assign unit_start = issue_fire ? unit_grant : '0;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    aii_unit #(
      .EX_CYC (EX_CYC),
      .WB_CYC (WB_CYC),
      .RW     (RW),
      .TAG_W  (TAG_W)
    ) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (unit_start[u]),
      .start_dst (in_dst),
      .start_tag (in_tag),
      .busy      (unit_busy[u]),
      .free      (unit_free[u]),
      .wb_last   (unit_last[u]),
      .dst       (u_dst[u]),
      .tag       (u_tag[u])
    );

    assign rf_waddr[u*RW +: RW]       = u_dst[u];
    assign rf_wtag[u*TAG_W +: TAG_W]  = u_tag[u];
  end

  always_comb begin
    reg_landing = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_last[u]) reg_landing[u_dst[u]] = 1'b1;
    end
  end

  aii_scoreboard #(
    .NUM_REGS (NUM_REGS),
    .RW       (RW)
  ) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (in_dst),
    .landing (reg_landing),
    .q_src_a (in_src_a),
    .q_src_b (in_src_b),
    .q_dst   (in_dst),
    .pending (reg_pending),
    .hazard  (dep_hazard)
  );

  assign rf_we      = unit_last;
  assign retire_cnt = pop_units(unit_last);

endmodule

// File: rtl/aii_checker.sv
module aii_checker #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_UNITS = 3,
  parameter int RW        = 4,
  parameter int CNT_W     = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [RW-1:0]           in_dst,
  input logic [RW-1:0]           in_src_a,
  input logic [RW-1:0]           in_src_b,
  input logic [NUM_UNITS-1:0]    rf_we,
  input logic [NUM_UNITS*RW-1:0] rf_waddr,
  input logic [CNT_W-1:0]        retire_cnt,
  input logic [NUM_REGS-1:0]     reg_pending,
  input logic [NUM_REGS-1:0]     reg_landing,
  input logic [NUM_UNITS-1:0]    unit_free,
  input logic [NUM_UNITS-1:0]    unit_busy,
  input logic [NUM_UNITS-1:0]    unit_start
);

  assert_single_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_start));

  assert_src_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |->
      (!reg_pending[in_src_a] || reg_landing[in_src_a]) &&
      (!reg_pending[in_src_b] || reg_landing[in_src_b]));

  assert_dst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (!reg_pending[in_dst] || reg_landing[in_dst]));

  assert_dst_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> reg_pending[$past(in_dst)]);

  assert_ready_has_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (unit_free != '0));

  assert_retire_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_cnt == CNT_W'($countones(rf_we)));

  assert_idle_no_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($countones(unit_busy) <= $past($countones(unit_busy))));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_wr
    assert_write_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we[u] |-> reg_pending[rf_waddr[u*RW +: RW]]);
  end

endmodule

bind add_issue_interlock aii_checker #(
  .NUM_REGS  (NUM_REGS),
  .NUM_UNITS (NUM_UNITS),
  .RW        (RW),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_dst      (in_dst),
  .in_src_a    (in_src_a),
  .in_src_b    (in_src_b),
  .rf_we       (rf_we),
  .rf_waddr    (rf_waddr),
  .retire_cnt  (retire_cnt),
  .reg_pending (reg_pending),
  .reg_landing (reg_landing),
  .unit_free   (unit_free),
  .unit_busy   (unit_busy),
  .unit_start  (unit_start)
);

// File: tb/tb_add_issue_interlock.sv
module tb_add_issue_interlock;

  localparam int NR = 16;
  localparam int NU = 3;
  localparam int RW = 4;
  localparam int TW = 8;
  localparam int LAST = 5;  // EX 3 + WB 2

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [TW-1:0] in_tag = '0;
  logic [NU-1:0] rf_we;
  logic [NU*RW-1:0] rf_waddr;
  logic [NU*TW-1:0] rf_wtag;
  logic [1:0]    retire_cnt;

  add_issue_interlock dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_tag(in_tag),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wtag(rf_wtag), .retire_cnt(retire_cnt)
  );

  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference timing model (per unit: cycles since issue, 0 = idle).
  int m_ph  [NU];
  int m_dst [NU];
  int m_tag [NU];
  bit m_pend[NR];
  int tag_ctr = 0;
  logic [NU-1:0] last_we;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit reg_waiting(input int r);
    bit landing = 1'b0;
    for (int u = 0; u < NU; u++)
      if (m_ph[u] == LAST && m_dst[u] == r) landing = 1'b1;
    return m_pend[r] && !landing;
  endfunction

  function automatic bit exp_ready(input int d, input int a, input int b);
    bit fr = 1'b0;
    for (int u = 0; u < NU; u++)
      if (m_ph[u] == 0 || m_ph[u] == LAST) fr = 1'b1;
    return fr && !reg_waiting(a) && !reg_waiting(b) && !reg_waiting(d);
  endfunction

  task automatic step(input bit v, input int d, input int a, input int b, output bit rdy);
    bit er;
    int nw;
    bit fire;
    in_valid = v;
    in_dst   = RW'(d);
    in_src_a = RW'(a);
    in_src_b = RW'(b);
    in_tag   = TW'(tag_ctr);
    #1;
    er = exp_ready(d, a, b);
    check(in_ready == er, "R2 R3 R5 in_ready", int'(in_ready), int'(er));
    nw = 0;
    for (int u = 0; u < NU; u++) begin
      bit ew = (m_ph[u] == LAST);
      check(rf_we[u] == ew, "R4 R6 rf_we", int'(rf_we[u]), int'(ew));
      if (ew) begin
        nw++;
        check(rf_waddr[u*RW +: RW] == RW'(m_dst[u]), "R4 rf_waddr",
              int'(rf_waddr[u*RW +: RW]), m_dst[u]);
        check(rf_wtag[u*TW +: TW] == TW'(m_tag[u]), "R4 rf_wtag",
              int'(rf_wtag[u*TW +: TW]), m_tag[u]);
      end
    end
    check(int'(retire_cnt) == nw, "R7 retire_cnt", int'(retire_cnt), nw);
    rdy     = in_ready;
    last_we = rf_we;
    fire    = v && er;
    @(posedge clk);
    for (int u = 0; u < NU; u++) begin
      if (m_ph[u] == LAST) begin
        m_pend[m_dst[u]] = 1'b0;
        m_ph[u] = 0;
      end else if (m_ph[u] > 0) begin
        m_ph[u]++;
      end
    end
    if (fire) begin
      for (int u = 0; u < NU; u++) begin
        if (m_ph[u] == 0) begin
          m_ph[u]  = 1;
          m_dst[u] = d;
          m_tag[u] = tag_ctr & 8'hFF;
          break;
        end
      end
      m_pend[d] = 1'b1;
      tag_ctr++;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    bit r;
    for (int i = 0; i < 7; i++) step(1'b0, 0, 0, 0, r);
  endtask

  // Offer one instruction until accepted; return the number of stalled cycles.
  task automatic offer(input int d, input int a, input int b, output int stalls);
    bit r;
    stalls = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1, d, a, b, r);
      if (r) break;
      stalls++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit r;
    int n;
    int wsum;
    for (int u = 0; u < NU; u++) begin m_ph[u] = 0; m_dst[u] = 0; m_tag[u] = 0; end
    for (int i = 0; i < NR; i++) m_pend[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(rf_we == '0, "R1 rf_we after reset", int'(rf_we), 0);
    check(retire_cnt == '0, "R1 retire_cnt after reset", int'(retire_cnt), 0);
    @(negedge clk);

    // R2: read-after-write stall of 4 cycles
    offer(1, 2, 3, n);
    offer(4, 1, 2, n);
    check(n == 4, "R2 raw stall cycles", n, 4);
    drain();

    // R3: write-after-write stall of 4 cycles
    offer(5, 8, 9, n);
    offer(5, 6, 7, n);
    check(n == 4, "R3 waw stall cycles", n, 4);
    drain();

    // R8 back-to-back, R5 structural stall, R6 reuse of unit 0
    offer(1, 8, 9, n); check(n == 0, "R8 first independent", n, 0);
    offer(2, 8, 9, n); check(n == 0, "R8 second independent", n, 0);
    offer(3, 8, 9, n); check(n == 0, "R8 third independent", n, 0);
    offer(4, 10, 11, n);
    check(n == 2, "R5 no-unit stall cycles", n, 2);
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, r);
    step(1'b0, 0, 0, 0, r);
    check(last_we == 3'b001, "R6 refilled unit 0 writes", int'(last_we), 1);
    drain();

    // R9: set and clear of the same register in one cycle
    offer(6, 8, 9, n);
    offer(6, 8, 9, n);
    check(n == 4, "R9 rewriter waits", n, 4);
    offer(7, 6, 6, n);
    check(n == 4, "R9 reader waits for new writer", n, 4);
    drain();

    // R10: idle cycle with ready high issues nothing
    step(1'b0, 9, 9, 9, r);
    check(r == 1'b1, "R10 ready while idle", int'(r), 1);
    wsum = 0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 0, 0, 0, r);
      wsum += $countones(last_we);
    end
    check(wsum == 0, "R10 no write from invalid cycle", wsum, 0);

    // Random mix over a small register window
    void'($urandom(32'd1447));
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      step(v, $urandom % 6, $urandom % 6, $urandom % 6, r);
    end
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule